// File: doc/BRIEF.md
# Instruction-Side Translation Buffer with Pairwise-LRU Refill

This block is a small, fully associative translation buffer on the instruction fetch path. Each lookup carries a virtual address, the current address-space identifier and a mode flag. When the flag is set, the identifier check is skipped. Every entry compares itself against the request in parallel. A single match is reported as a hit, along with the entry index, the translated physical address and the entry's stored flags. Two or more matches are reported as a multi-hit. On every hit the block updates a 6-bit pairwise recency word.

When no entry matches, the block holds the request on a second-level port and waits for a larger unified translation buffer to answer. If that answer is a hit, the block picks the least recently used slot from the recency word and writes the returned entry into it. It then reports the lookup as a hit on that slot. If the unified buffer also misses or multi-hits, that outcome is forwarded to the requester and no slot is written. One lookup is in flight at a time, and `lk_ready` shows when a new one is accepted.

Top module: `itlb_lru_refill`

## Requirements
- R1: After reset, every entry is invalid and the recency word is zero. So no result is pending, `lk_ready` is 1, `ut_req` is 0, the first lookup misses, and the first refill lands in entry 3.
- R2: Entry flag bits have these positions: bit 8 valid, bit 1 shared. Bits {7,4} hold the page-size code: 00 for 1 KB, 01 for 4 KB, 10 for 64 KB, 11 for 1 MB. An entry matches when three things hold: it is valid; it is shared or its identifier equals `lk_asid`; and all virtual address bits at or above the page size equal the stored page number.
- R3: With `lk_any_asid` set, the identifier/shared condition is dropped from the match.
- R4: Two or more matching entries give `res_kind` 2 (multi-hit). They leave the recency word unchanged and raise no second-level request.
- R5: A hit on entry k updates the recency word (bit 5 is the MSB) as follows. Entry 0: AND with 0x07. Entry 1: AND with 0x19, then OR with 0x20. Entry 2: AND with 0x3E, then OR with 0x14. Entry 3: OR with 0x0B.
- R6: The replacement slot is found by testing, in order: entry 0 if (word AND 0x38) = 0x38; entry 1 if (word AND 0x26) = 0x06; entry 2 if (word AND 0x15) = 0x01. Otherwise entry 3 is used.
- R7: On a second-level hit (`ut_rsp_kind` 0), the chosen slot takes the returned page number, identifier and frame number. Its flags become `ut_rsp_flags` AND 0x1DA. The recency word is updated as for a hit on that slot, and the lookup is reported with `res_kind` 0 and that slot's index.
- R8: A second-level miss (kind 1) or multi-hit (kind 2) is forwarded unchanged in `res_kind`. No entry is written and the recency word is not touched.
- R9: From the cycle after a missing lookup is accepted until the response cycle, three things hold: `ut_req` stays 1 with `ut_vaddr`, `ut_asid` and `ut_any_asid` held at the request's values; `lk_ready` is 0; and the result outputs hold their values with `res_valid` low.
- R10: `res_valid` pulses for one cycle. For a hit or multi-hit it comes one clock after the lookup is accepted. For a miss it comes one clock after the cycle in which `ut_rsp_valid` is seen.
- R11: On a hit, `res_paddr` takes its bits at or above the page size from the frame number, and its bits below the page size from the virtual address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | High when a lookup can be accepted |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_any_asid | input | 1 | Skip the identifier/shared check |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 0 hit, 1 miss, 2 multi-hit |
| res_idx | output | log2(ENTRIES) | Entry index for a hit |
| res_paddr | output | PA_W | Translated physical address for a hit |
| res_flags | output | 9 | Stored flags of the hit entry |
| ut_req | output | 1 | Second-level request, held until answered |
| ut_vaddr | output | VA_W | Address sent with the second-level request |
| ut_asid | output | ASID_W | Identifier sent with the second-level request |
| ut_any_asid | output | 1 | Mode flag sent with the second-level request |
| ut_rsp_valid | input | 1 | Second-level response strobe |
| ut_rsp_kind | input | 2 | 0 hit, 1 miss, 2 multi-hit |
| ut_rsp_vpn | input | VA_W-10 | Returned virtual page number |
| ut_rsp_asid | input | ASID_W | Returned identifier |
| ut_rsp_ppn | input | PA_W-10 | Returned frame number |
| ut_rsp_flags | input | 9 | Returned flags, before masking |

## Verification
A hit or multi-hit is due on the first clock after the accepting edge. A miss raises `ut_req` at that same edge. The refill result is due on the first clock after the response edge. The driver works out each expected outcome from a model of the entries and the recency word. It records the outcome with the cycle number at which it is due. The monitor compares on the falling edge and checks both the values and the arrival cycle. While a response is delayed, the driver checks on every falling edge that the request stays up and no result appears.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
   localparam int unsigned FLAG_W = 9;
   localparam int unsigned PG_LO  = 10;
   localparam logic [FLAG_W-1:0] FLAG_KEEP = 9'h1DA;
   localparam int unsigned F_VALID = 8;
   localparam int unsigned F_SZ_HI = 7;
   localparam int unsigned F_SZ_LO = 4;
   localparam int unsigned F_SHARE = 1;

   typedef enum logic [1:0] {
      RK_HIT   = 2'd0,
      RK_MISS  = 2'd1,
      RK_MULTI = 2'd2
   } res_kind_e;

   // lowest address bit that belongs to the page number for a size code
   function automatic int unsigned page_shift(logic [1:0] sz);
      case (sz)
         2'b00:   return 10;
         2'b01:   return 12;
         2'b10:   return 16;
         default: return 20;
      endcase
   endfunction
endpackage

// File: rtl/itlb_tag_cmp.sv
module itlb_tag_cmp
   import itlb_pkg::*;
#(
   parameter int unsigned VA_W   = 32,
   parameter int unsigned ASID_W = 8,
   localparam int unsigned VPN_W = VA_W - PG_LO
) (
   input  logic              ent_valid,
   input  logic              ent_share,
   input  logic [1:0]        ent_size,
   input  logic [VPN_W-1:0]  ent_vpn,
   input  logic [ASID_W-1:0] ent_asid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              req_any_asid,
   output logic              match
);
   logic [VPN_W-1:0] cmp_mask;
   logic             id_ok;
   logic             page_ok;

   always_comb begin
      for (int unsigned b = 0; b < VPN_W; b++) begin
         cmp_mask[b] = ((b + PG_LO) >= page_shift(ent_size));
      end
   end

   assign id_ok   = req_any_asid || ent_share || (ent_asid == req_asid);
   assign page_ok = (((ent_vpn ^ req_vpn) & cmp_mask) == '0);
   assign match   = ent_valid && id_ok && page_ok;
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru #(
   parameter int unsigned N = 4,
   localparam int unsigned IW = $clog2(N),
   localparam int unsigned PW = N * (N - 1) / 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim
);
   // pair (i,j), i<j, owns one bit; 1 means j was used after i
   function automatic int pbit(int i, int j);
      return int'(PW) - 1 - (i * int'(N) - (i * (i + 1)) / 2 + (j - i - 1));
   endfunction

   logic [PW-1:0] order_q, order_d;

   always_comb begin
      order_d = order_q;
      for (int a = 0; a < int'(N); a++) begin
         for (int b = a + 1; b < int'(N); b++) begin
            if (touch_idx == IW'(a)) order_d[pbit(a, b)] = 1'b0;
            else if (touch_idx == IW'(b)) order_d[pbit(a, b)] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     order_q <= '0;
      else if (touch) order_q <= order_d;
   end

   always_comb begin : vsel
      logic oldest;
      victim = IW'(N - 1);
      for (int v = int'(N) - 2; v >= 0; v--) begin
         oldest = 1'b1;
         for (int o = 0; o < int'(N); o++) begin
            if (o < v)      oldest = oldest & ~order_q[pbit(o, v)];
            else if (o > v) oldest = oldest &  order_q[pbit(v, o)];
         end
         if (oldest) victim = IW'(v);
      end
   end
endmodule

// File: rtl/itlb_lru_refill.sv
module itlb_lru_refill
   import itlb_pkg::*;
#(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PA_W    = 29,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IW     = $clog2(ENTRIES),
   localparam int unsigned VPN_W  = VA_W - PG_LO,
   localparam int unsigned PPN_W  = PA_W - PG_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   output logic              lk_ready,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_any_asid,
   output logic              res_valid,
   output logic [1:0]        res_kind,
   output logic [IW-1:0]     res_idx,
   output logic [PA_W-1:0]   res_paddr,
   output logic [FLAG_W-1:0] res_flags,
   output logic              ut_req,
   output logic [VA_W-1:0]   ut_vaddr,
   output logic [ASID_W-1:0] ut_asid,
   output logic              ut_any_asid,
   input  logic              ut_rsp_valid,
   input  logic [1:0]        ut_rsp_kind,
   input  logic [VPN_W-1:0]  ut_rsp_vpn,
   input  logic [ASID_W-1:0] ut_rsp_asid,
   input  logic [PPN_W-1:0]  ut_rsp_ppn,
   input  logic [FLAG_W-1:0] ut_rsp_flags
);
   if (ENTRIES < 2 || ENTRIES > 8) begin : g_bad_entries
      $error("itlb_lru_refill: ENTRIES must be 2..8");
   end
   if (VA_W <= 20 || PA_W <= 20) begin : g_bad_width
      $error("itlb_lru_refill: address widths must exceed the largest page");
   end
   if (PA_W > VA_W) begin : g_bad_pa
      $error("itlb_lru_refill: PA_W must not exceed VA_W");
   end

   function automatic logic [PA_W-1:0] form_paddr(logic [PPN_W-1:0] ppn,
                                                  logic [1:0] sz,
                                                  logic [PA_W-1:0] off);
      logic [PA_W-1:0] r;
      int unsigned sh;
      sh = page_shift(sz);
      for (int unsigned b = 0; b < PA_W; b++) begin
         if (b >= sh && b >= PG_LO) r[b] = ppn[b - PG_LO];
         else                       r[b] = off[b];
      end
      return r;
   endfunction

   // entry storage
   logic [VPN_W-1:0]  ent_vpn   [ENTRIES];
   logic [ASID_W-1:0] ent_asid  [ENTRIES];
   logic [PPN_W-1:0]  ent_ppn   [ENTRIES];
   logic [FLAG_W-1:0] ent_flags [ENTRIES];

   // lookup side
   logic [ENTRIES-1:0] hit_vec;
   logic [IW-1:0]      hit_idx;
   logic               multi;
   logic               accept;
   logic               one_hit;

   // control state
   logic              wait_q;
   logic [VA_W-1:0]   req_va_q;
   logic [ASID_W-1:0] req_asid_q;
   logic              req_any_q;
   logic              res_valid_q;
   logic [1:0]        res_kind_q;
   logic [IW-1:0]     res_idx_q;
   logic [PA_W-1:0]   res_pa_q;
   logic [FLAG_W-1:0] res_fl_q;

   // refill side
   logic              fill_we;
   logic [FLAG_W-1:0] fill_flags;
   logic [IW-1:0]     victim;
   logic              lru_touch;
   logic [IW-1:0]     lru_idx;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      itlb_tag_cmp #(.VA_W(VA_W), .ASID_W(ASID_W)) u_cmp (
         .ent_valid    (ent_flags[e][F_VALID]),
         .ent_share    (ent_flags[e][F_SHARE]),
         .ent_size     ({ent_flags[e][F_SZ_HI], ent_flags[e][F_SZ_LO]}),
         .ent_vpn      (ent_vpn[e]),
         .ent_asid     (ent_asid[e]),
         .req_vpn      (lk_vaddr[VA_W-1:PG_LO]),
         .req_asid     (lk_asid),
         .req_any_asid (lk_any_asid),
         .match        (hit_vec[e])
      );
   end

   always_comb begin
      hit_idx = '0;
      for (int unsigned e = 0; e < ENTRIES; e++) begin
         if (hit_vec[e]) hit_idx = IW'(e);
      end
   end

   assign multi      = !$onehot0(hit_vec);
   assign accept     = lk_valid && !wait_q;
   assign one_hit    = accept && (|hit_vec) && !multi;
   assign fill_we    = wait_q && ut_rsp_valid && (ut_rsp_kind == RK_HIT);
   assign fill_flags = ut_rsp_flags & FLAG_KEEP;
   assign lru_touch  = one_hit || fill_we;
   assign lru_idx    = fill_we ? victim : hit_idx;

   itlb_lru #(.N(ENTRIES)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (lru_touch),
      .touch_idx (lru_idx),
      .victim    (victim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned e = 0; e < ENTRIES; e++) begin
            ent_vpn[e]   <= '0;
            ent_asid[e]  <= '0;
            ent_ppn[e]   <= '0;
            ent_flags[e] <= '0;
         end
      end else if (fill_we) begin
         for (int unsigned e = 0; e < ENTRIES; e++) begin
            if (victim == IW'(e)) begin
               ent_vpn[e]   <= ut_rsp_vpn;
               ent_asid[e]  <= ut_rsp_asid;
               ent_ppn[e]   <= ut_rsp_ppn;
               ent_flags[e] <= fill_flags;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wait_q      <= 1'b0;
         req_va_q    <= '0;
         req_asid_q  <= '0;
         req_any_q   <= 1'b0;
         res_valid_q <= 1'b0;
         res_kind_q  <= RK_HIT;
         res_idx_q   <= '0;
         res_pa_q    <= '0;
         res_fl_q    <= '0;
      end else begin
         res_valid_q <= 1'b0;
         if (accept) begin
            if (multi) begin
               res_valid_q <= 1'b1;
               res_kind_q  <= RK_MULTI;
            end else if (one_hit) begin
               res_valid_q <= 1'b1;
               res_kind_q  <= RK_HIT;
               res_idx_q   <= hit_idx;
               res_pa_q    <= form_paddr(ent_ppn[hit_idx],
                                         {ent_flags[hit_idx][F_SZ_HI], ent_flags[hit_idx][F_SZ_LO]},
                                         lk_vaddr[PA_W-1:0]);
               res_fl_q    <= ent_flags[hit_idx];
            end else begin
               wait_q     <= 1'b1;
               req_va_q   <= lk_vaddr;
               req_asid_q <= lk_asid;
               req_any_q  <= lk_any_asid;
            end
         end else if (wait_q && ut_rsp_valid) begin
            wait_q      <= 1'b0;
            res_valid_q <= 1'b1;
            res_kind_q  <= ut_rsp_kind;
            if (fill_we) begin
               res_idx_q <= victim;
               res_pa_q  <= form_paddr(ut_rsp_ppn,
                                       {ut_rsp_flags[F_SZ_HI], ut_rsp_flags[F_SZ_LO]},
                                       req_va_q[PA_W-1:0]);
               res_fl_q  <= fill_flags;
            end
         end
      end
   end

   assign lk_ready    = !wait_q;
   assign ut_req      = wait_q;
   assign ut_vaddr    = req_va_q;
   assign ut_asid     = req_asid_q;
   assign ut_any_asid = req_any_q;
   assign res_valid   = res_valid_q;
   assign res_kind    = res_kind_q;
   assign res_idx     = res_idx_q;
   assign res_paddr   = res_pa_q;
   assign res_flags   = res_fl_q;
endmodule

// File: rtl/itlb_lru_refill_chk.sv
module itlb_lru_refill_chk #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned VA_W    = 32,
   parameter int unsigned PA_W    = 29,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IW     = $clog2(ENTRIES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic              lk_ready,
   input logic              ut_req,
   input logic [VA_W-1:0]   ut_vaddr,
   input logic [ASID_W-1:0] ut_asid,
   input logic              ut_any_asid,
   input logic              ut_rsp_valid,
   input logic [1:0]        ut_rsp_kind,
   input logic              res_valid,
   input logic [1:0]        res_kind,
   input logic [IW-1:0]     res_idx,
   input logic [PA_W-1:0]   res_paddr
);
   // R9: request held steady until answered
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ut_req && !ut_rsp_valid |=> ut_req && $stable(ut_vaddr) && $stable(ut_asid) && $stable(ut_any_asid));

   // R9: no new lookup accepted while waiting
   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ut_req |-> !lk_ready);

   // R9: result outputs frozen while waiting
   p_res_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ut_req |-> !res_valid && $stable(res_kind) && $stable(res_idx) && $stable(res_paddr));

   // R10: an accepted lookup yields either a result or a request next cycle
   p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_ready |=> (res_valid != ut_req));

   // R10: response closes the request and yields a result next cycle
   p_rsp_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ut_req && ut_rsp_valid |=> res_valid && !ut_req);

   // R7: second-level hit is reported as a hit
   p_fill_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ut_req && ut_rsp_valid && (ut_rsp_kind == 2'd0) |=> res_kind == 2'd0);

   // R8: other second-level outcomes are forwarded unchanged
   p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ut_req && ut_rsp_valid && (ut_rsp_kind != 2'd0) |=> res_kind == $past(ut_rsp_kind));
endmodule

bind itlb_lru_refill itlb_lru_refill_chk #(
   .ENTRIES (ENTRIES),
   .VA_W    (VA_W),
   .PA_W    (PA_W),
   .ASID_W  (ASID_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_valid     (lk_valid),
   .lk_ready     (lk_ready),
   .ut_req       (ut_req),
   .ut_vaddr     (ut_vaddr),
   .ut_asid      (ut_asid),
   .ut_any_asid  (ut_any_asid),
   .ut_rsp_valid (ut_rsp_valid),
   .ut_rsp_kind  (ut_rsp_kind),
   .res_valid    (res_valid),
   .res_kind     (res_kind),
   .res_idx      (res_idx),
   .res_paddr    (res_paddr)
);

// File: tb/itlb_lru_refill_tb.sv
module itlb_lru_refill_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic        lk_ready;
   logic [31:0] lk_vaddr = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_any_asid = 1'b0;
   logic        res_valid;
   logic [1:0]  res_kind;
   logic [1:0]  res_idx;
   logic [28:0] res_paddr;
   logic [8:0]  res_flags;
   logic        ut_req;
   logic [31:0] ut_vaddr;
   logic [7:0]  ut_asid;
   logic        ut_any_asid;
   logic        ut_rsp_valid = 1'b0;
   logic [1:0]  ut_rsp_kind = '0;
   logic [21:0] ut_rsp_vpn = '0;
   logic [7:0]  ut_rsp_asid = '0;
   logic [18:0] ut_rsp_ppn = '0;
   logic [8:0]  ut_rsp_flags = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   itlb_lru_refill u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
      .lk_vaddr(lk_vaddr), .lk_asid(lk_asid), .lk_any_asid(lk_any_asid),
      .res_valid(res_valid), .res_kind(res_kind), .res_idx(res_idx),
      .res_paddr(res_paddr), .res_flags(res_flags), .ut_req(ut_req),
      .ut_vaddr(ut_vaddr), .ut_asid(ut_asid), .ut_any_asid(ut_any_asid),
      .ut_rsp_valid(ut_rsp_valid), .ut_rsp_kind(ut_rsp_kind), .ut_rsp_vpn(ut_rsp_vpn),
      .ut_rsp_asid(ut_rsp_asid), .ut_rsp_ppn(ut_rsp_ppn), .ut_rsp_flags(ut_rsp_flags)
   );

   typedef struct {
      logic [1:0]  kind;
      logic [1:0]  idx;
      logic [28:0] pa;
      logic [8:0]  fl;
      int          due;
      string       req;
   } exp_t;

   exp_t sb[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   int   cyc     = 0;
   bit   done    = 1'b0;

   // reference model
   logic [21:0] m_vpn  [4];
   logic [7:0]  m_asid [4];
   logic [18:0] m_ppn  [4];
   logic [8:0]  m_fl   [4];
   logic [5:0]  m_lru;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic int m_shift(logic [8:0] f);
      case ({f[7], f[4]})
         2'b00:   return 10;
         2'b01:   return 12;
         2'b10:   return 16;
         default: return 20;
      endcase
   endfunction

   function automatic bit m_match(int e, logic [31:0] va, logic [7:0] asid, bit any);
      logic [31:0] msk;
      msk = 32'hFFFF_FFFF << m_shift(m_fl[e]);
      return m_fl[e][8] && (any || m_fl[e][1] || m_asid[e] == asid) &&
             ((({m_vpn[e], 10'b0}) ^ va) & msk) == 32'd0;
   endfunction

   function automatic logic [28:0] m_pa(logic [18:0] ppn, logic [8:0] fl, logic [31:0] va);
      logic [31:0] msk, t;
      msk = 32'hFFFF_FFFF << m_shift(fl);
      t = ({3'b000, ppn, 10'b0} & msk) | (va & ~msk);
      return t[28:0];
   endfunction

   task automatic m_touch(input int e);
      case (e)
         0: m_lru = m_lru & 6'h07;
         1: m_lru = (m_lru & 6'h19) | 6'h20;
         2: m_lru = (m_lru & 6'h3E) | 6'h14;
         default: m_lru = m_lru | 6'h0B;
      endcase
   endtask

   function automatic int m_victim();
      if ((m_lru & 6'h38) == 6'h38) return 0;
      if ((m_lru & 6'h26) == 6'h06) return 1;
      if ((m_lru & 6'h15) == 6'h01) return 2;
      return 3;
   endfunction

   // driver: one lookup, plus the second-level answer when the model misses
   task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input bit any,
                         input logic [1:0] uk, input logic [18:0] uppn, input logic [8:0] ufl,
                         input int dly, input string req);
      exp_t ex;
      int nm;
      int hi;
      int v;
      nm = 0;
      hi = 0;
      for (int e = 0; e < 4; e++) if (m_match(e, va, asid, any)) begin nm++; hi = e; end
      @(negedge clk);
      lk_vaddr = va; lk_asid = asid; lk_any_asid = any; lk_valid = 1'b1;
      ex.req = req; ex.due = cyc + 1; ex.idx = 2'(hi); ex.pa = '0; ex.fl = '0;
      if (nm == 1) begin
         ex.kind = 2'd0; ex.pa = m_pa(m_ppn[hi], m_fl[hi], va); ex.fl = m_fl[hi];
         sb.push_back(ex);
         m_touch(hi);
      end else if (nm > 1) begin
         ex.kind = 2'd2;
         sb.push_back(ex);
      end
      @(negedge clk);
      lk_valid = 1'b0;
      if (nm != 0) begin
         chk(ut_req == 1'b0, req, "no second-level request on hit/multi", 32'(ut_req), 0);
      end else begin
         chk(ut_req == 1'b1 && ut_vaddr == va, "R9", "request address", ut_vaddr, va);
         chk(ut_asid == asid && ut_any_asid == any, "R9", "request id/mode",
             {ut_any_asid, ut_asid}, {any, asid});
         chk(lk_ready == 1'b0, "R9", "busy while waiting", 32'(lk_ready), 0);
         for (int d = 0; d < dly; d++) begin
            @(negedge clk);
            chk(ut_req == 1'b1 && res_valid == 1'b0, "R9", "hold during wait",
                {ut_req, res_valid}, 2'b10);
         end
         ut_rsp_kind = uk; ut_rsp_vpn = va[31:10]; ut_rsp_asid = asid;
         ut_rsp_ppn = uppn; ut_rsp_flags = ufl; ut_rsp_valid = 1'b1;
         ex.due = cyc + 1;
         if (uk == 2'd0) begin
            v = m_victim();
            m_vpn[v] = va[31:10]; m_asid[v] = asid; m_ppn[v] = uppn; m_fl[v] = ufl & 9'h1DA;
            ex.kind = 2'd0; ex.idx = 2'(v); ex.pa = m_pa(uppn, m_fl[v], va); ex.fl = m_fl[v];
            m_touch(v);
         end else begin
            ex.kind = uk;
         end
         sb.push_back(ex);
         @(negedge clk);
         ut_rsp_valid = 1'b0;
         chk(ut_req == 1'b0, "R10", "request closed after response", 32'(ut_req), 0);
      end
      @(negedge clk);
   endtask

   // monitor
   always @(negedge clk) begin : mon
      exp_t ex;
      if (rst_n && res_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R10", "unexpected result", 32'(res_kind), 0);
         end else begin
            ex = sb.pop_front();
            chk(cyc == ex.due, "R10", "result cycle", cyc, ex.due);
            chk(res_kind == ex.kind, ex.req, "result kind", 32'(res_kind), 32'(ex.kind));
            if (ex.kind == 2'd0) begin
               chk(res_idx == ex.idx, ex.req, "hit index", 32'(res_idx), 32'(ex.idx));
               chk(res_paddr == ex.pa, "R11", "physical address", 32'(res_paddr), 32'(ex.pa));
               chk(res_flags == ex.fl, ex.req, "entry flags", 32'(res_flags), 32'(ex.fl));
            end
         end
      end
   end

   initial begin : wdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : stim
      for (int e = 0; e < 4; e++) begin
         m_vpn[e] = '0; m_asid[e] = '0; m_ppn[e] = '0; m_fl[e] = '0;
      end
      m_lru = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(res_valid == 1'b0 && ut_req == 1'b0 && lk_ready == 1'b1, "R1", "reset outputs",
          {res_valid, ut_req, lk_ready}, 3'b001);
      // R1/R6/R7: first miss refills entry 3, flags masked
      lookup(32'h0000_1234, 8'h05, 1'b0, 2'd0, 19'h00ABC, 9'h145, 0, "R7");
      // R2/R5: same address hits entry 3
      lookup(32'h0000_1234, 8'h05, 1'b0, 2'd0, 19'h0, 9'h0, 0, "R2");
      // R2: other id misses; delayed answer (R9); refill entry 2 (R6)
      lookup(32'h0000_1234, 8'h06, 1'b0, 2'd0, 19'h00DEF, 9'h100, 3, "R6");
      // R3/R4: any-id mode matches both -> multi-hit
      lookup(32'h0000_1234, 8'h07, 1'b1, 2'd0, 19'h0, 9'h0, 0, "R4");
      // R6: shared 1 MB page refills entry 1
      lookup(32'h0052_3456, 8'h09, 1'b0, 2'd0, 19'h12345, 9'h192, 1, "R6");
      // R2: shared bit matches a foreign id; R11 on 1 MB page
      lookup(32'h005F_FFFC, 8'h33, 1'b0, 2'd0, 19'h0, 9'h0, 0, "R2");
      // R8: second-level miss and multi-hit forwarded
      lookup(32'h0000_8000, 8'h05, 1'b0, 2'd1, 19'h0, 9'h0, 2, "R8");
      lookup(32'h0000_9000, 8'h05, 1'b0, 2'd2, 19'h0, 9'h0, 0, "R8");
      // R6/R8: replacement state untouched -> entry 0 chosen now; 64 KB page
      lookup(32'h0002_0000, 8'h05, 1'b0, 2'd0, 19'h07700, 9'h1C4, 0, "R6");
      // R8: entry 3 was not replaced by the forwarded outcomes
      lookup(32'h0000_1234, 8'h05, 1'b0, 2'd0, 19'h0, 9'h0, 0, "R8");
      // R5: hits on entry 0 and entry 2 reorder the word
      lookup(32'h0002_FFFF, 8'h05, 1'b0, 2'd0, 19'h0, 9'h0, 0, "R5");
      lookup(32'h0000_1300, 8'h06, 1'b0, 2'd0, 19'h0, 9'h0, 0, "R5");
      // R3/R6: any-id miss, 4 KB page lands in entry 1
      lookup(32'h0100_0000, 8'h05, 1'b1, 2'd0, 19'h0AAAA, 9'h115, 2, "R6");
      // R11: 4 KB page offset kept
      lookup(32'h0100_0ABC, 8'h05, 1'b0, 2'd0, 19'h0, 9'h0, 0, "R11");
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R10", "all results delivered", sb.size(), 0);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule